// File: doc/BRIEF.md
# Daisy-Chain Serial Event Readout Sequencer

This block empties a chip's local event store over one serial data line that a whole chain of chips shares. Readout happens only while acquisition is halted. The chip waits for a readout token on either of two redundant token inputs. It then turns on its line driver and sends every stored event back to back, oldest first. Each event is its per-channel hit codes, then its bunch-crossing stamp, then the chip's own identifier. Finally it raises both of its token outputs for one cycle, so that the next chip, or the one after a dead neighbour, takes the line.

The driver is modelled as an open-collector enable. It is on only during the chip's own turn, and the data pin reads low whenever the driver is off. Events come in through a simple write port from the capture logic, which is not part of this block. A readout empties the store.

Top module: `chain_readout`

## Requirements
- R1: After a synchronous reset, `line_oe`, `line_data`, `tok_out_a` and `tok_out_b` are low and the store holds no events.
- R2: A 0-to-1 change on `tok_in_a` or on `tok_in_b`, seen at a clock edge while idle with `acq_run` low, starts readout. `line_oe` is high from the cycle after that edge, and the first data bit appears one cycle later.
- R3: Each event is 160 bits, sent MSB first: the 2-bit codes of channel 63 down to channel 0, each code MSB first (`wr_codes[2k+1:2k]` is channel k), then the 24-bit `wr_bcid`, then the 8-bit `chip_id`.
- R4: All stored events are sent oldest first with no idle cycle between them, one bit per clock.
- R5: In the cycle after the last bit, `tok_out_a` and `tok_out_b` are both high for exactly one cycle and `line_oe` is low. Neither token output is high while data is being sent.
- R6: With an empty store, a start pulses both token outputs in the cycle after the start edge, and `line_oe` stays low.
- R7: A rising edge on either token input during readout has no effect on the stream, and it does not cause a second readout.
- R8: A token edge while `acq_run` is high is ignored, and the stored events are kept for a later readout.
- R9: A write is stored only while the block is idle and the store holds fewer than DEPTH (127) events. Writes made during readout or to a full store are dropped.
- R10: `line_data` is low whenever `line_oe` is low.
- R11: After a readout completes, the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_run | input | 1 | High while acquisition is running; blocks readout |
| wr_en | input | 1 | Store one event |
| wr_codes | input | 128 | Per-channel 2-bit codes, channel k at bits [2k+1:2k] |
| wr_bcid | input | 24 | Bunch-crossing stamp of the event |
| chip_id | input | 8 | Identifier appended to every event |
| tok_in_a | input | 1 | Readout token input, primary |
| tok_in_b | input | 1 | Readout token input, bypass |
| line_data | output | 1 | Serial data bit |
| line_oe | output | 1 | Open-collector driver enable |
| tok_out_a | output | 1 | Completion token, primary |
| tok_out_b | output | 1 | Completion token, bypass |

## Verification
The stream is checked bit by bit for four kinds of store contents. An empty store separates the immediate token pass from a stream. One event started on the bypass input shows that the second token line is honoured. Two events with distinct codes and stamps expose event ordering and any gap at the event boundary. A store written past its capacity shows that the 128th and later writes are dropped and that the last slot is still read. Token edges and writes injected in the middle of a stream, and a token edge while acquisition runs, show that those inputs change neither the bits sent nor the store's contents.

// File: rtl/chain_readout_pkg.sv
package chain_readout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/chain_token_rx.sv
module chain_token_rx #(
  parameter int NLINE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINE-1:0] tok_in,
  output logic             tok_rise
);
  logic [NLINE-1:0] prev_q;
  logic [NLINE-1:0] rise_vec;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= tok_in[g];
    end
    assign rise_vec[g] = tok_in[g] & ~prev_q[g];
  end

  assign tok_rise = |rise_vec;
endmodule

// File: rtl/chain_event_store.sv
module chain_event_store #(
  parameter int NCH    = 64,
  parameter int CODE_W = 2,
  parameter int BCID_W = 24,
  parameter int DEPTH  = 127
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [NCH*CODE_W-1:0]        wr_codes,
  input  logic [BCID_W-1:0]            wr_bcid,
  input  logic                         busy,
  input  logic                         clr,
  input  logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic [NCH*CODE_W+BCID_W-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int DW = NCH*CODE_W + BCID_W;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [2**AW];
  logic [CW-1:0] count_q;
  logic          accept;

  assign accept = wr_en && !busy && (count_q < CW'(DEPTH));

  // block-RAM style: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (accept) mem[count_q[AW-1:0]] <= {wr_codes, wr_bcid};
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)         count_q <= '0;
    else if (clr)    count_q <= '0;
    else if (accept) count_q <= count_q + CW'(1);
  end

  assign count = count_q;

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  a_r9_busy_blocks_write: assert property (@(posedge clk) disable iff (rst)
    (busy && !clr) |=> $stable(count_q));
  a_r11_cleared_after_drain: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count_q == '0));
endmodule

// File: rtl/chain_serializer.sv
module chain_serializer
  import chain_readout_pkg::*;
#(
  parameter int NCH    = 64,
  parameter int CODE_W = 2,
  parameter int BCID_W = 24,
  parameter int ID_W   = 8,
  parameter int DEPTH  = 127
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tok_rise,
  input  logic                         acq_run,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic [NCH*CODE_W+BCID_W-1:0] rd_data,
  input  logic [ID_W-1:0]              chip_id,
  output logic [$clog2(DEPTH)-1:0]     rd_addr,
  output logic                         busy,
  output logic                         clr,
  output logic                         line_data,
  output logic                         line_oe,
  output logic                         tok_done
);
  localparam int EVW = NCH*CODE_W + BCID_W + ID_W;
  localparam int BW  = $clog2(EVW);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH+1);

  rd_state_e      state_q;
  logic [EVW-1:0] shreg_q;
  logic [BW-1:0]  bit_q;
  logic [CW-1:0]  ev_q;
  logic [AW-1:0]  addr_q;
  logic           oe_q;
  logic           done_q;
  logic           last_bit;
  logic           last_ev;

  assign last_bit = (bit_q == BW'(EVW-1));
  assign last_ev  = ((ev_q + CW'(1)) == count);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      ev_q    <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tok_rise && !acq_run) begin
            if (count == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_FETCH;
              oe_q    <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          shreg_q <= {rd_data, chip_id};
          bit_q   <= '0;
          ev_q    <= '0;
          addr_q  <= addr_q + AW'(1);
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (!last_bit) begin
            shreg_q <= {shreg_q[EVW-2:0], 1'b0};
            bit_q   <= bit_q + BW'(1);
          end else if (last_ev) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
            done_q  <= 1'b1;
            addr_q  <= '0;
          end else begin
            shreg_q <= {rd_data, chip_id};
            bit_q   <= '0;
            ev_q    <= ev_q + CW'(1);
            addr_q  <= addr_q + AW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr   = addr_q;
  assign busy      = (state_q != ST_IDLE);
  assign clr       = (state_q == ST_SHIFT) && last_bit && last_ev;
  assign line_data = oe_q & shreg_q[EVW-1];
  assign line_oe   = oe_q;
  assign tok_done  = done_q;

  a_r5_token_single_cycle: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r5_release_with_token: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_q) |-> done_q);
  a_r5_no_token_while_driving: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> !done_q);
  a_r2_first_bit_follows_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |=> (state_q == ST_SHIFT));
  a_r7_busy_ignores_token: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && !last_bit && tok_rise) |=> (state_q == ST_SHIFT));
  a_r8_acq_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && acq_run) |=> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/chain_readout.sv
module chain_readout #(
  parameter int NCH    = 64,
  parameter int CODE_W = 2,
  parameter int BCID_W = 24,
  parameter int ID_W   = 8,
  parameter int DEPTH  = 127
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acq_run,
  input  logic                  wr_en,
  input  logic [NCH*CODE_W-1:0] wr_codes,
  input  logic [BCID_W-1:0]     wr_bcid,
  input  logic [ID_W-1:0]       chip_id,
  input  logic                  tok_in_a,
  input  logic                  tok_in_b,
  output logic                  line_data,
  output logic                  line_oe,
  output logic                  tok_out_a,
  output logic                  tok_out_b
);
  localparam int DW = NCH*CODE_W + BCID_W;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic          tok_rise;
  logic          busy;
  logic          clr;
  logic          tok_done;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] count;

  chain_token_rx #(.NLINE(2)) u_tok (
    .clk      (clk),
    .rst      (rst),
    .tok_in   ({tok_in_b, tok_in_a}),
    .tok_rise (tok_rise)
  );

  chain_event_store #(
    .NCH(NCH), .CODE_W(CODE_W), .BCID_W(BCID_W), .DEPTH(DEPTH)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_codes (wr_codes),
    .wr_bcid  (wr_bcid),
    .busy     (busy),
    .clr      (clr),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .count    (count)
  );

  chain_serializer #(
    .NCH(NCH), .CODE_W(CODE_W), .BCID_W(BCID_W), .ID_W(ID_W), .DEPTH(DEPTH)
  ) u_ser (
    .clk       (clk),
    .rst       (rst),
    .tok_rise  (tok_rise),
    .acq_run   (acq_run),
    .count     (count),
    .rd_data   (rd_data),
    .chip_id   (chip_id),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .clr       (clr),
    .line_data (line_data),
    .line_oe   (line_oe),
    .tok_done  (tok_done)
  );

  assign tok_out_a = tok_done;
  assign tok_out_b = tok_done;

  a_r10_line_released: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> !line_data);
  a_r5_outputs_paired: assert property (@(posedge clk) disable iff (rst)
    tok_out_a == tok_out_b);
endmodule

// File: tb/chain_readout_test.sv
module chain_readout_test;
  localparam int NCH    = 64;
  localparam int CODE_W = 2;
  localparam int BCID_W = 24;
  localparam int ID_W   = 8;
  localparam int DEPTH  = 127;
  localparam int SW     = NCH*CODE_W + BCID_W;
  localparam int EVW    = SW + ID_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acq_run = 1'b0;
  logic wr_en = 1'b0;
  logic [NCH*CODE_W-1:0] wr_codes = '0;
  logic [BCID_W-1:0] wr_bcid = '0;
  logic [ID_W-1:0] chip_id = 8'h5A;
  logic tok_in_a = 1'b0;
  logic tok_in_b = 1'b0;
  logic line_data, line_oe, tok_out_a, tok_out_b;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [SW-1:0] mev [DEPTH];
  int mcount = 0;

  always #2.5 clk = ~clk;

  chain_readout uut (
    .clk(clk), .rst(rst), .acq_run(acq_run), .wr_en(wr_en),
    .wr_codes(wr_codes), .wr_bcid(wr_bcid), .chip_id(chip_id),
    .tok_in_a(tok_in_a), .tok_in_b(tok_in_b),
    .line_data(line_data), .line_oe(line_oe),
    .tok_out_a(tok_out_a), .tok_out_b(tok_out_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NCH*CODE_W-1:0] mk_codes(input int e);
    logic [NCH*CODE_W-1:0] r;
    for (int j = 0; j < NCH*CODE_W/32; j++)
      r[32*j +: 32] = 32'(e*4 + j + 1) * 32'h9E3779B1;
    return r;
  endfunction

  // write one event; the model stores it when the requirement says it is kept
  task automatic put_event(input int e);
    @(negedge clk);
    wr_en = 1'b1;
    wr_codes = mk_codes(e);
    wr_bcid = 24'(e * 24'h01F3A7 + 5);
    if (mcount < DEPTH) begin
      mev[mcount] = {mk_codes(e), 24'(e * 24'h01F3A7 + 5)};
      mcount++;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // start a readout and check every output cycle by cycle
  task automatic run_readout(input bit use_b, input bit poke, input string req);
    logic [EVW-1:0] word;
    @(negedge clk);
    if (use_b) tok_in_b = 1'b1; else tok_in_a = 1'b1;
    @(negedge clk);
    tok_in_a = 1'b0;
    tok_in_b = 1'b0;
    if (mcount == 0) begin
      chk({line_oe, tok_out_a, tok_out_b} == 3'b011, {"R6 empty token pass ", req},
          {line_oe, tok_out_a, tok_out_b}, 3'b011);
      @(negedge clk);
      chk({line_oe, tok_out_a, tok_out_b, line_data} == 4'b0000, {"R6 token one cycle ", req},
          {line_oe, tok_out_a, tok_out_b, line_data}, 4'b0000);
      return;
    end
    chk({line_oe, tok_out_a, tok_out_b} == 3'b100, {"R2 enable before data ", req},
        {line_oe, tok_out_a, tok_out_b}, 3'b100);
    for (int e = 0; e < mcount; e++) begin
      word = {mev[e], chip_id};
      for (int i = 0; i < EVW; i++) begin
        @(negedge clk);
        chk({line_oe, tok_out_a, tok_out_b, line_data} == {3'b100, word[EVW-1-i]},
            {"R3 R4 stream bit ", req},
            {e[15:0], i[11:0], line_oe, tok_out_a, tok_out_b, line_data},
            {e[15:0], i[11:0], 3'b100, word[EVW-1-i]});
        if (poke && e == 0 && i == 5) begin
          tok_in_b = 1'b1;   // R7: token edge while busy
          wr_en = 1'b1;      // R9: write while busy
          wr_codes = '1;
          wr_bcid = '1;
        end
        if (poke && e == 0 && i == 6) begin
          tok_in_b = 1'b0;
          wr_en = 1'b0;
        end
        if (poke && e == 0 && i == 9) tok_in_a = 1'b1;
        if (poke && e == 0 && i == 10) tok_in_a = 1'b0;
      end
    end
    @(negedge clk);
    chk({line_oe, tok_out_a, tok_out_b, line_data} == 4'b0110, {"R5 end token ", req},
        {line_oe, tok_out_a, tok_out_b, line_data}, 4'b0110);
    @(negedge clk);
    chk({line_oe, tok_out_a, tok_out_b, line_data} == 4'b0000, {"R5 R10 released ", req},
        {line_oe, tok_out_a, tok_out_b, line_data}, 4'b0000);
    mcount = 0;
  endtask

  task automatic quiet_cycles(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({line_oe, tok_out_a, tok_out_b, line_data} == 4'b0000, req,
          {line_oe, tok_out_a, tok_out_b, line_data}, 4'b0000);
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({line_oe, tok_out_a, tok_out_b, line_data} == 4'b0000, "R1 reset outputs",
        {line_oe, tok_out_a, tok_out_b, line_data}, 4'b0000);
    run_readout(1'b0, 1'b0, "R1 empty after reset");
  endtask

  task automatic t_two_events;
    put_event(1);
    put_event(2);
    run_readout(1'b0, 1'b0, "R2 two events on input a");
    run_readout(1'b0, 1'b0, "R11 store drained");
  endtask

  task automatic t_bypass_input;
    chip_id = 8'hC3;
    put_event(7);
    run_readout(1'b1, 1'b0, "R2 one event on input b");
  endtask

  task automatic t_busy_pokes;
    put_event(11);
    run_readout(1'b0, 1'b1, "R7 token and write during readout");
    quiet_cycles(4, "R7 no second readout");
    run_readout(1'b0, 1'b0, "R9 write during readout dropped");
  endtask

  task automatic t_acq_blocks;
    put_event(20);
    put_event(21);
    acq_run = 1'b1;
    @(negedge clk);
    tok_in_a = 1'b1;
    @(negedge clk);
    tok_in_a = 1'b0;
    quiet_cycles(6, "R8 start ignored while acquiring");
    acq_run = 1'b0;
    run_readout(1'b0, 1'b0, "R8 events kept after blocked start");
  endtask

  task automatic t_full_store;
    for (int e = 0; e < DEPTH + 3; e++) put_event(100 + e);
    chk(mcount == DEPTH, "R9 model holds capacity", mcount, DEPTH);
    run_readout(1'b1, 1'b0, "R9 full store, extra writes dropped");
    run_readout(1'b0, 1'b0, "R11 empty after full drain");
  endtask

  initial begin
    t_reset();
    t_two_events();
    t_bypass_input();
    t_busy_pokes();
    t_acq_blocks();
    t_full_store();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule